// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds eight binary tokens that two independent agents, called the left side and the right side, use to coordinate ownership of shared resources. The tokens sit in their own small address space, apart from any data memory. A side enters that space with its select strobe and picks a token with the low three bits of its address. It asks for a token by writing a zero on data bit 0 and gives it back by writing a one. A read returns the token state as that side sees it: zero means "mine", one means "not mine".

Each token keeps one request register per side and a pair of ownership flags, at most one of which is set. A request that arrives while the other side holds the token stays pending. When the holder lets go, the pending side receives the token on the same clock edge, without having to write again. If both sides ask for a free token on the same edge, the left side wins. The read value is captured when the read window opens and is held until the window closes, so the other side cannot change it during that time.

All state updates on the rising clock edge. Reset is synchronous and active high.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free, and both sides read one on every index.
- R2: A side's token index is the low three address bits. All higher address bits are ignored, so two addresses with equal low bits reach the same token.
- R3: A write (select and write enable high) uses only data bit 0. A zero stores a request and a one stores a release. The other data bits have no effect.
- R4: A request for a free token grants that token to the requester on the same edge. From the next cycle on, the requester reads zero and the other side reads one.
- R5: A request from the side that does not hold the token stays pending. The holder keeps reading zero and the requester keeps reading one.
- R6: When the holder releases and the other side has no pending request, the token becomes free and both sides read one.
- R7: When the holder releases while the other side has a pending request, ownership passes to the other side on the same edge.
- R8: At most one side owns a token at any time. No write from the non-holder removes ownership from the holder.
- R9: When both sides request a free token on the same edge, the left side gets it. If one side requests in an earlier cycle, that side gets it.
- R10: The read bus carries the flag bit copied onto every bit: all ones for one, all zeros for zero.
- R11: The read window is select and output enable high with write enable low. The flag is captured in the first cycle of the window, and the read bus holds that value until the window closes, even if the token changes in the meantime.
- R12: A release written by the non-holder withdraws its pending request, so a later release by the holder leaves the token free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left side semaphore-space select |
| l_we | input | 1 | Left side write enable |
| l_oe | input | 1 | Left side output enable |
| l_addr | input | ADDR_W | Left side address; low three bits pick the token |
| l_wdata | input | DATA_W | Left side write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left side read bus, flag copied onto every bit |
| r_sel | input | 1 | Right side semaphore-space select |
| r_we | input | 1 | Right side write enable |
| r_oe | input | 1 | Right side output enable |
| r_addr | input | ADDR_W | Right side address; low three bits pick the token |
| r_wdata | input | DATA_W | Right side write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right side read bus, flag copied onto every bit |

## Verification
A corrupted request register has no visible effect while the token is held. It only appears when the holder releases: the token then goes to the wrong side or becomes free when it should have been handed over, and this shows on the first read after that edge. A wrong ownership flag shows on the next read window of either side, as zero on both buses or as a holder that reads one. A latch that re-captures during an open window shows as a change on the read bus in the cycle after the other side's write. For this reason the bench holds windows open across writes from the other side.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int SEM_IDX_W = 3;
    localparam int SEM_NUM   = 1 << SEM_IDX_W;

    typedef logic [SEM_NUM-1:0]   sem_vec_t;
    typedef logic [SEM_IDX_W-1:0] sem_idx_t;

    // decoded write request from one side
    typedef struct packed {
        logic     wr;
        sem_idx_t idx;
        logic     val;   // 0 = request, 1 = release
    } sem_wr_t;

    // ownership pair for one token
    typedef struct packed {
        logic own_l;
        logic own_r;
    } sem_own_t;

    function automatic sem_wr_t decode_wr(input logic sel, input logic we,
                                          input sem_idx_t idx, input logic d0);
        sem_wr_t w;
        w.wr  = sel & we;
        w.idx = idx;
        w.val = d0;
        return w;
    endfunction

    function automatic logic read_win(input logic sel, input logic oe, input logic we);
        return sel & oe & ~we;
    endfunction

    // grant resolution for one token given next request levels (active low)
    function automatic sem_own_t resolve(input sem_own_t cur, input logic rq_l_n,
                                         input logic rq_r_n);
        sem_own_t n;
        if (cur.own_l) begin
            n.own_l = ~rq_l_n;
            n.own_r = rq_l_n & ~rq_r_n;
        end else if (cur.own_r) begin
            n.own_r = ~rq_r_n;
            n.own_l = rq_r_n & ~rq_l_n;
        end else begin
            n.own_l = ~rq_l_n;
            n.own_r = rq_l_n & ~rq_r_n;
        end
        return n;
    endfunction

endpackage

// File: rtl/sem_req_bank.sv
module sem_req_bank
    import sem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sem_wr_t  l_wr,
    input  sem_wr_t  r_wr,
    output sem_vec_t req_l_q,
    output sem_vec_t req_r_q,
    output sem_vec_t req_l_nxt,
    output sem_vec_t req_r_nxt
);

    for (genvar i = 0; i < SEM_NUM; i++) begin : g_req
        localparam sem_idx_t MY_IDX = sem_idx_t'(i);

        always_comb begin
            req_l_nxt[i] = (l_wr.wr && l_wr.idx == MY_IDX) ? l_wr.val : req_l_q[i];
            req_r_nxt[i] = (r_wr.wr && r_wr.idx == MY_IDX) ? r_wr.val : req_r_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                req_l_q[i] <= 1'b1;
                req_r_q[i] <= 1'b1;
            end else begin
                req_l_q[i] <= req_l_nxt[i];
                req_r_q[i] <= req_r_nxt[i];
            end
        end
    end

endmodule

// File: rtl/sem_grant.sv
module sem_grant
    import sem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sem_vec_t req_l_nxt,
    input  sem_vec_t req_r_nxt,
    output sem_vec_t own_l,
    output sem_vec_t own_r
);

    for (genvar i = 0; i < SEM_NUM; i++) begin : g_tok
        sem_own_t cur, nxt;

        always_comb begin
            cur.own_l = own_l[i];
            cur.own_r = own_r[i];
            nxt = resolve(cur, req_l_nxt[i], req_r_nxt[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                own_l[i] <= 1'b0;
                own_r[i] <= 1'b0;
            end else begin
                own_l[i] <= nxt.own_l;
                own_r[i] <= nxt.own_r;
            end
        end
    end

endmodule

// File: rtl/sem_read_latch.sv
module sem_read_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata
);

    logic win_q;
    logic held;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            held  <= 1'b1;
        end else begin
            win_q <= win;
            if (win && !win_q)
                held <= flag;
        end
    end

    assign rdata = {DATA_W{held}};

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    sem_wr_t  l_wr, r_wr;
    sem_vec_t req_l_q, req_r_q, req_l_nxt, req_r_nxt;
    sem_vec_t own_l, own_r;
    sem_idx_t l_idx, r_idx;
    logic     l_flag, r_flag;

    assign l_idx = l_addr[SEM_IDX_W-1:0];
    assign r_idx = r_addr[SEM_IDX_W-1:0];
    assign l_wr  = decode_wr(l_sel, l_we, l_idx, l_wdata[0]);
    assign r_wr  = decode_wr(r_sel, r_we, r_idx, r_wdata[0]);

    sem_req_bank u_req (
        .clk       (clk),
        .rst       (rst),
        .l_wr      (l_wr),
        .r_wr      (r_wr),
        .req_l_q   (req_l_q),
        .req_r_q   (req_r_q),
        .req_l_nxt (req_l_nxt),
        .req_r_nxt (req_r_nxt)
    );

    sem_grant u_grant (
        .clk       (clk),
        .rst       (rst),
        .req_l_nxt (req_l_nxt),
        .req_r_nxt (req_r_nxt),
        .own_l     (own_l),
        .own_r     (own_r)
    );

    // active-low flag seen by each side
    assign l_flag = ~own_l[l_idx];
    assign r_flag = ~own_r[r_idx];

    sem_read_latch #(.DATA_W(DATA_W)) u_lrd (
        .clk   (clk),
        .rst   (rst),
        .win   (read_win(l_sel, l_oe, l_we)),
        .flag  (l_flag),
        .rdata (l_rdata)
    );

    sem_read_latch #(.DATA_W(DATA_W)) u_rrd (
        .clk   (clk),
        .rst   (rst),
        .win   (read_win(r_sel, r_oe, r_we)),
        .flag  (r_flag),
        .rdata (r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              l_sel,
    input logic              l_we,
    input logic              l_oe,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              r_sel,
    input logic              r_we,
    input logic              r_oe,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input sem_vec_t          own_l,
    input sem_vec_t          own_r,
    input sem_vec_t          req_l_q,
    input sem_vec_t          req_r_q
);

    logic l_win, r_win;
    assign l_win = l_sel & l_oe & ~l_we;
    assign r_win = r_sel & r_oe & ~r_we;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (own_l == '0 && own_r == '0));

    assert_replicate_R10: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == {DATA_W{l_rdata[0]}}) && (r_rdata == {DATA_W{r_rdata[0]}}));

    assert_hold_l_R11: assert property (@(posedge clk) disable iff (rst)
        l_win && $past(l_win) && !$past(rst) |-> $stable(l_rdata));

    assert_hold_r_R11: assert property (@(posedge clk) disable iff (rst)
        r_win && $past(r_win) && !$past(rst) |-> $stable(r_rdata));

    for (genvar i = 0; i < SEM_NUM; i++) begin : g_chk
        localparam sem_idx_t MY_IDX = sem_idx_t'(i);
        logic l_rel, r_rel;
        assign l_rel = l_sel && l_we && l_addr[SEM_IDX_W-1:0] == MY_IDX && l_wdata[0];
        assign r_rel = r_sel && r_we && r_addr[SEM_IDX_W-1:0] == MY_IDX && r_wdata[0];

        assert_mutex_R8: assert property (@(posedge clk) disable iff (rst)
            $onehot0({own_l[i], own_r[i]}));

        assert_keep_l_R8: assert property (@(posedge clk) disable iff (rst)
            own_l[i] && !l_rel |=> own_l[i]);

        assert_keep_r_R8: assert property (@(posedge clk) disable iff (rst)
            own_r[i] && !r_rel |=> own_r[i]);

        assert_handoff_l_R7: assert property (@(posedge clk) disable iff (rst)
            own_l[i] && l_rel && !req_r_q[i] && !r_rel |=> own_r[i]);

        assert_handoff_r_R7: assert property (@(posedge clk) disable iff (rst)
            own_r[i] && r_rel && !req_l_q[i] && !l_rel |=> own_l[i]);
    end

endmodule

bind sem_bank sem_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sem_bank_tb.sv
module sem_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 16;
    localparam logic [DW-1:0] ONES  = '1;
    localparam logic [DW-1:0] ZEROS = '0;

    logic clk = 1'b0;
    logic rst;
    logic l_sel, l_we, l_oe, r_sel, r_we, r_oe;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        l_sel = 0; l_we = 0; l_oe = 0; l_addr = '0; l_wdata = '0;
        r_sel = 0; r_we = 0; r_oe = 0; r_addr = '0; r_wdata = '0;
    endtask

    // side: 0 = left, 1 = right
    task automatic wr(input bit side, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (!side) begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
        else       begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
        @(negedge clk);
        idle_all();
    endtask

    task automatic wr_both(input logic [AW-1:0] al, input logic [DW-1:0] dl,
                           input logic [AW-1:0] ar, input logic [DW-1:0] dr);
        @(negedge clk);
        l_sel = 1; l_we = 1; l_addr = al; l_wdata = dl;
        r_sel = 1; r_we = 1; r_addr = ar; r_wdata = dr;
        @(negedge clk);
        idle_all();
    endtask

    task automatic rd(input bit side, input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        if (!side) begin l_sel = 1; l_oe = 1; l_addr = a; end
        else       begin r_sel = 1; r_oe = 1; r_addr = a; end
        @(negedge clk);
        v = side ? r_rdata : l_rdata;
        idle_all();
    endtask

    task automatic expect_rd(input string tag, input bit side, input logic [AW-1:0] a,
                             input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(side, a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            expect_rd("R1 left free after reset", 0, AW'(i), ONES);
            expect_rd("R1 right free after reset", 1, AW'(i), ONES);
        end
    endtask

    task automatic t_acquire_handoff();
        wr(0, 3, 16'h0000);
        expect_rd("R4 left owns", 0, 3, ZEROS);
        expect_rd("R4 right sees taken", 1, 3, ONES);
        expect_rd("R4 other token untouched", 0, 4, ONES);
        wr(1, 3, 16'h0000);
        expect_rd("R5 holder keeps", 0, 3, ZEROS);
        expect_rd("R5 pending still one", 1, 3, ONES);
        wr(1, 3, 16'h0000);
        expect_rd("R8 repeated request no steal", 0, 3, ZEROS);
        wr(0, 3, 16'h0001);
        expect_rd("R7 handoff right owns", 1, 3, ZEROS);
        expect_rd("R7 left released", 0, 3, ONES);
        wr(0, 3, 16'h0000);
        expect_rd("R8 left request no steal", 1, 3, ZEROS);
        wr(0, 3, 16'h0001);
        wr(1, 3, 16'h0001);
        expect_rd("R6 free left", 0, 3, ONES);
        expect_rd("R6 free right", 1, 3, ONES);
    endtask

    task automatic t_alias();
        wr(0, 15'h7FFD, 16'h0000);
        expect_rd("R2 left via low bits", 0, 15'h0005, ZEROS);
        expect_rd("R2 right aliased addr", 1, 15'h2A05, ONES);
        wr(1, 15'h1235, 16'h0000);
        wr(0, 15'h0F05, 16'h0001);
        expect_rd("R2 right got via alias", 1, 15'h0005, ZEROS);
        wr(1, 15'h4005, 16'h0001);
        expect_rd("R2 free again", 0, 5, ONES);
    endtask

    task automatic t_bit0();
        wr(0, 1, 16'hFFFE);
        expect_rd("R3 bit0 zero requests", 0, 1, ZEROS);
        wr(0, 1, 16'h0001);
        expect_rd("R3 bit0 one releases", 0, 1, ONES);
        wr(1, 1, 16'h8000);
        expect_rd("R3 upper bits ignored", 1, 1, ZEROS);
        wr(1, 1, 16'h7FFF);
        expect_rd("R3 release with upper bits", 1, 1, ONES);
    endtask

    task automatic t_simul();
        wr_both(2, 16'h0000, 2, 16'h0000);
        expect_rd("R9 tie left wins", 0, 2, ZEROS);
        expect_rd("R9 tie right loses", 1, 2, ONES);
        wr(0, 2, 16'h0001);
        expect_rd("R7 loser granted after tie", 1, 2, ZEROS);
        wr(1, 2, 16'h0001);
        wr(1, 6, 16'h0000);
        wr(0, 6, 16'h0000);
        expect_rd("R9 earlier right wins", 1, 6, ZEROS);
        expect_rd("R9 later left waits", 0, 6, ONES);
        wr(0, 6, 16'h0001);
        wr(1, 6, 16'h0001);
        expect_rd("R12 withdrawn request not granted", 0, 6, ONES);
        expect_rd("R12 token free for right", 1, 6, ONES);
    endtask

    task automatic t_latch();
        wr(1, 0, 16'h0000);
        wr(0, 0, 16'h0000);
        @(negedge clk);
        l_sel = 1; l_oe = 1; l_addr = 0;
        @(negedge clk);
        chk("R11 window captures one", l_rdata, ONES);
        r_sel = 1; r_we = 1; r_addr = 0; r_wdata = 16'h0001;
        @(negedge clk);
        r_sel = 0; r_we = 0; r_wdata = '0;
        @(negedge clk);
        chk("R11 held across other side release", l_rdata, ONES);
        l_addr = 7;
        @(negedge clk);
        chk("R11 held across index change", l_rdata, ONES);
        idle_all();
        expect_rd("R11 reopen shows new owner", 0, 0, ZEROS);
        expect_rd("R10 right read all ones", 1, 0, ONES);
        wr(0, 0, 16'h0001);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 left bus after reset", l_rdata, ONES);
        t_reset();
        t_acquire_handoff();
        t_alias();
        t_bit0();
        t_simul();
        t_latch();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule